// File: doc/BRIEF.md
# Interval Timer with Counter Latch

A single down-counting timer channel in the style of the classic PC interval timer. Software reaches it only through byte-wide operations. A program strobe loads a 16-bit start count and clears the expiry status. Each tick strobe then lowers the count by one until it expires, and expiry raises bit 5 of the status byte.

The count is read as two bytes through one data port, low byte first. A counter-latch control word freezes a snapshot of the count. The channel returns the snapshot's low byte and then its high byte, and the snapshot is dropped once the high byte has been read. With no snapshot pending, the first read returns the live low byte and every read after it returns the live high byte.

Control words that this channel does not support raise a one-cycle error pulse and leave the state untouched. The parameter `CHAN_SEL` (0 or 2) sets the selector value that addresses this channel. The other of those two values addresses a sibling channel, and this channel ignores it.

Top module: `interval_timer_latch`

## Requirements
- R1: After reset the live count is 0, no snapshot is pending, the byte pointer points at the low byte, `status` is 0x00, `expired` is low, and `rd_data` shows 0x00.
- R2: A cycle with `prog_valid` high loads `prog_count` into the live count and clears `status` to 0x00 at the next edge, and it takes priority over a tick in the same cycle.
- R3: A cycle with `tick` high, no `prog_valid` and no expiry decrements the live count by one, wrapping from 0 to 0xFFFF. Once the channel has expired, ticks leave the count unchanged.
- R4: A tick that takes the live count from 1 to 0 sets `status` to 0x20 (bit 5) and `expired` high from the next cycle. A start count of 0 therefore expires after 65536 ticks.
- R5: A control write with bits 5:4 = 11 causes no state change and no error. A control write with bits 5:4 = 01 or 10 pulses `cmd_err` high in that same cycle only, and it changes no state.
- R6: A control write with bits 5:4 = 00 and bits 7:6 = `CHAN_SEL` copies the live count (its value before that edge) into the snapshot and points the byte pointer at the low byte. Bits 7:6 equal to the other supported selector (`CHAN_SEL` ^ 2) are ignored. Bits 7:6 equal to 01 or 11 pulse `cmd_err` and change no state.
- R7: A latch command that arrives while a snapshot is pending is ignored, and the first snapshot is kept.
- R8: While a snapshot is pending, a read returns the snapshot's low byte if the pointer is at the low byte and moves the pointer to the high byte. Otherwise it returns the snapshot's high byte and releases the snapshot.
- R9: With no snapshot pending, a read returns the live low byte when the pointer is at the low byte, and the live high byte otherwise. Every such read leaves the pointer at the high byte. Programming does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle count strobe |
| prog_valid | input | 1 | Load strobe for a new start count |
| prog_count | input | 16 | Start count loaded by `prog_valid` |
| ctrl_wr | input | 1 | Control-word write strobe |
| ctrl_data | input | 8 | Control word |
| rd | input | 1 | Data-byte read strobe |
| rd_data | output | 8 | Byte returned in the same cycle as `rd` |
| status | output | 8 | 0x20 when expired, else 0x00 |
| expired | output | 1 | Terminal-count indication |
| cmd_err | output | 1 | Pulse for an unsupported control word |

## Verification
Directed sequences separate the snapshot path from the live path. A latch is followed by ticks and then two reads, so a snapshot that drifts with the count is caught. A second latch issued while one is pending must not refresh the held value, and the read that follows the release must return the live high byte. Every control-word pattern is applied once, which tells the supported latch, the ignored sibling selector, the no-action access mode and the error-raising codes apart. Start counts of 1 and 0 test the expiry edge and the wrap through 65536 ticks. A fixed-seed random mix of program, tick, control and read operations is then compared cycle by cycle with a model written from the requirements.

// File: rtl/interval_timer_latch.sv
module interval_timer_latch #(
  parameter int CW = 16,
  parameter int CHAN_SEL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          prog_valid,
  input  logic [CW-1:0] prog_count,
  input  logic          ctrl_wr,
  input  logic [7:0]    ctrl_data,
  input  logic          rd,
  output logic [7:0]    rd_data,
  output logic [7:0]    status,
  output logic          expired,
  output logic          cmd_err
);
  localparam logic [1:0] MY_SEL    = 2'(CHAN_SEL);
  localparam logic [1:0] OTHER_SEL = MY_SEL ^ 2'b10;
  localparam int         HB        = CW / 2;

  logic [CW-1:0] cnt_q, snap_q;
  logic          snap_on, hi_ptr, exp_q;

  wire [1:0] acc = ctrl_data[5:4];
  wire [1:0] sel = ctrl_data[7:6];
  wire latch_cmd = ctrl_wr && acc == 2'b00 && sel == MY_SEL;
  wire do_latch  = latch_cmd && !snap_on;
  wire bad_acc   = acc == 2'b01 || acc == 2'b10;
  wire bad_sel   = acc == 2'b00 && sel != MY_SEL && sel != OTHER_SEL;
  wire do_tick   = tick && !prog_valid && !exp_q;

  assign cmd_err = ctrl_wr && (bad_acc || bad_sel);
  assign expired = exp_q;
  assign status  = {2'b00, exp_q, 5'b00000};

  wire [CW-1:0] src = snap_on ? snap_q : cnt_q;
  assign rd_data = hi_ptr ? src[CW-1:HB] : src[HB-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (prog_valid) begin
      cnt_q <= prog_count;
      exp_q <= 1'b0;
    end else if (do_tick) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) exp_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q  <= '0;
      snap_on <= 1'b0;
      hi_ptr  <= 1'b0;
    end else if (do_latch) begin
      snap_q  <= cnt_q;
      snap_on <= 1'b1;
      hi_ptr  <= 1'b0;
    end else if (rd) begin
      if (snap_on && hi_ptr) snap_on <= 1'b0;
      hi_ptr <= 1'b1;
    end
  end

  assert_prog_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |=> cnt_q == $past(prog_count) && !exp_q);

  assert_tick_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !prog_valid && !exp_q |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_hold_after_exp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q && !prog_valid |=> $stable(cnt_q) && exp_q);

  assert_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !prog_valid && !exp_q && cnt_q == CW'(1) |=> exp_q && status == 8'h20);

  assert_err_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err && !rd |=> $stable(snap_on) && $stable(hi_ptr) && $stable(snap_q));

  assert_snap_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snap_on && !rd |=> snap_on && $stable(snap_q));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snap_on && hi_ptr && rd && !ctrl_wr |=> !snap_on);

  assert_live_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_on && rd && !ctrl_wr |=> hi_ptr);
endmodule

// File: tb/interval_timer_latch_test.sv
`timescale 1ns/1ps
module interval_timer_latch_test;
  logic clk = 0, rst_n = 0;
  logic tick = 0, prog_valid = 0, ctrl_wr = 0, rd = 0;
  logic [15:0] prog_count = 0;
  logic [7:0]  ctrl_data = 0;
  wire  [7:0]  rd_data, status;
  wire         expired, cmd_err;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [15:0] m_cnt, m_snap;
  bit m_on, m_hi, m_exp;

  interval_timer_latch #(.CW(16), .CHAN_SEL(0)) uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic bit f_err(input [7:0] cd);
    return cd[5:4] == 2'b01 || cd[5:4] == 2'b10 ||
           (cd[5:4] == 2'b00 && (cd[7:6] == 2'b01 || cd[7:6] == 2'b11));
  endfunction

  function automatic [7:0] f_byte();
    logic [15:0] s;
    s = m_on ? m_snap : m_cnt;
    return m_hi ? s[15:8] : s[7:0];
  endfunction

  task automatic cyc(input bit p, input [15:0] pc, input bit t,
                     input bit cw, input [7:0] cd, input bit r, input string req);
    prog_valid = p; prog_count = pc; tick = t; ctrl_wr = cw; ctrl_data = cd; rd = r;
    #1;
    chk("R4 status", status, m_exp ? 8'h20 : 8'h00);
    chk("R5 cmd_err", cmd_err, cw && f_err(cd));
    if (r) chk(req, rd_data, f_byte());
    if (p) begin m_cnt = pc; m_exp = 0; end
    else if (t && !m_exp) begin
      if (m_cnt == 16'd1) m_exp = 1;
      m_cnt = m_cnt - 1'b1;
    end
    if (cw && cd[5:4] == 2'b00 && cd[7:6] == 2'b00 && !m_on) begin
      m_snap = (p || (t && !m_exp)) ? m_snap : m_snap;
      m_on = 1; m_hi = 0;
    end else if (r) begin
      if (m_on && m_hi) m_on = 0;
      m_hi = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, "");
  endtask

  logic [15:0] pre;
  task automatic latch(input string req);
    pre = m_cnt;
    if (!m_on) m_snap = pre;
    cyc(0, 0, 0, 1, 8'h00, 0, req);
  endtask

  initial begin
    m_cnt = 0; m_snap = 0; m_on = 0; m_hi = 0; m_exp = 0;
    repeat (3) @(negedge clk);
    chk("R1 status", status, 0);
    chk("R1 expired", expired, 0);
    chk("R1 rd_data", rd_data, 0);
    rst_n = 1;
    @(negedge clk);

    cyc(1, 16'h1234, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 1, "R9 live low");
    chk("R9 low byte", m_cnt[7:0] == 8'h34, 1);
    cyc(0, 0, 1, 0, 0, 1, "R9 live high");
    cyc(0, 0, 1, 0, 0, 1, "R3 after ticks");
    chk("R3 model", m_cnt, 16'h1232);
    cyc(1, 16'h0500, 1, 0, 0, 1, "R2 prog beats tick");
    cyc(0, 0, 0, 0, 0, 1, "R2 loaded high");

    latch("R6 latch");
    repeat (5) cyc(0, 0, 1, 0, 0, 0, "");
    latch("R7 second latch");
    cyc(0, 0, 0, 0, 0, 1, "R8 snap low");
    cyc(0, 0, 1, 0, 0, 1, "R8 snap high");
    cyc(0, 0, 0, 0, 0, 1, "R8 release live high");

    cyc(0, 0, 0, 1, 8'h80, 0, "R6 sibling");
    cyc(0, 0, 0, 0, 0, 1, "R6 sibling ignored");
    cyc(0, 0, 0, 1, 8'h30, 0, "R5 lsb-msb mode");
    cyc(0, 0, 0, 1, 8'h10, 0, "R5 bad mode");
    cyc(0, 0, 0, 1, 8'h20, 0, "R5 bad mode");
    cyc(0, 0, 0, 1, 8'hC0, 0, "R6 readback");
    cyc(0, 0, 0, 1, 8'h40, 0, "R6 bad sel");
    cyc(0, 0, 0, 0, 0, 1, "R5 no state change");

    cyc(1, 16'd1, 0, 0, 0, 0, "R4");
    cyc(0, 0, 1, 0, 0, 0, "R4");
    chk("R4 expired", expired, 1);
    chk("R4 status", status, 8'h20);
    cyc(0, 0, 1, 0, 0, 0, "R3");
    latch("R3 hold");
    cyc(0, 0, 0, 0, 0, 1, "R3 hold low");
    cyc(0, 0, 0, 0, 0, 1, "R3 hold high");

    cyc(1, 16'd0, 0, 0, 0, 0, "R4 zero");
    repeat (65535) cyc(0, 0, 1, 0, 0, 0, "");
    chk("R4 not yet", expired, 0);
    cyc(0, 0, 1, 0, 0, 0, "");
    chk("R4 zero expiry", expired, 1);

    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] cd;
      bit p, t, cw, r;
      p = ($urandom % 40) == 0;
      t = ($urandom % 2) == 0;
      cw = ($urandom % 6) == 0;
      r = ($urandom % 3) == 0;
      cd = $urandom;
      if ($urandom % 2) cd[5:4] = 2'b00;
      if (cw && cd[5:4] == 2'b00 && cd[7:6] == 2'b00 && !m_on) m_snap = m_cnt;
      cyc(p, 16'($urandom % 64), t, cw, cd, r, "R8 R9 random read");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule